// File: doc/BRIEF.md
# Undervoltage Load-Shed Monitor

This block turns a debounced undervoltage level from a bus power monitor into two control outputs for a power-loss response. When undervoltage is first seen, the block raises a loss-of-power flag at once and fires a one-shot load-shed pulse of fixed length. When the supply recovers, the flag stays up until the input has read clear for an unbroken qualification window. Only then does the flag drop. If undervoltage returns at any time inside that window, the window starts again from zero.

All timing comes from a one-cycle `tick` strobe that the surrounding logic supplies. The input is read only on tick cycles, and both windows are counted in ticks. With a 10 ms tick, the default settings give a 1 s shed pulse (`SHED_TICKS` = 100) and a 60 s off-delay (`HOLD_TICKS` = 6000). Debouncing of the input and the load sequencing that follows are handled by neighbouring blocks.

Top module: `uv_shed_monitor`

## Requirements
- R1: On a tick cycle where `uvIn` is 1, the `uvIn` value read on the previous tick was 0, `lossOfPower` is 0 and no shed pulse is running, `shedPulse` rises after that clock edge. It then stays high for exactly `SHED_TICKS` ticks and falls at the edge of the `SHED_TICKS`-th tick that follows.
- R2: On any tick cycle where `uvIn` is 1, `lossOfPower` is 1 after that edge.
- R3: `lossOfPower` falls at the edge of the `HOLD_TICKS`-th consecutive tick on which `uvIn` is read as 0. It does not fall earlier.
- R4: A tick that reads `uvIn` = 1 while the clear window is running restarts the window, so a full `HOLD_TICKS` of clear ticks is needed again.
- R5: No new shed pulse starts while `lossOfPower` is 1. A running pulse is never reloaded, so its width is not stretched by undervoltage toggling during the pulse.
- R6: `uvIn` is ignored on cycles where `tick` is 0. Both outputs change only on tick edges or by reset.
- R7: Synchronous active-high `rst` clears both outputs, both counters and the stored previous input sample. A clear window that was partly counted before reset does not shorten the next one.
- R8: Because reset treats the previous sample as clear, `uvIn` held at 1 through reset release counts as an onset on the first tick after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle time-base strobe; the input is read and the timers advance only on these cycles |
| uvIn | input | 1 | Debounced undervoltage level, 1 = undervoltage present |
| shedPulse | output | 1 | One-shot load-shed pulse, `SHED_TICKS` ticks wide |
| lossOfPower | output | 1 | Loss-of-power flag with a restartable clear-side off-delay |

## Verification
The bench builds the block with `SHED_TICKS` = 5 and `HOLD_TICKS` = 12. These small values bring the full pulse width, the exact tick on which the off-delay expires, and a brief one-tick return of undervoltage inside the clear window into a run of a few dozen ticks. With a shed window shorter than the hold window, the bench can also show that a pulse is not reloaded when undervoltage toggles while it is running. It can likewise show that reset discards a partly counted clear window.

// File: rtl/uv_shed_pkg.sv
package uv_shed_pkg;

  // Strobes from the control FSM to the timer datapath.
  typedef struct packed {
    logic shedLoad;   // start a new shed pulse
    logic shedStep;   // advance the running shed pulse by one tick
    logic holdClr;    // restart the clear-window count
    logic holdStep;   // count one more clear tick
  } uv_strobe_t;

  function automatic int cntWidth(input int maxVal);
    return (maxVal < 2) ? 1 : $clog2(maxVal + 1);
  endfunction

endpackage

// File: rtl/uv_tick_counter.sv
module uv_tick_counter #(
  parameter int WIDTH   = 8,
  parameter bit COUNTUP = 1'b1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             step,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] stepped;

  generate
    if (COUNTUP) begin : g_up
      assign stepped = count + WIDTH'(1);
    end else begin : g_down
      assign stepped = count - WIDTH'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (step) begin
      count <= stepped;
    end
  end

endmodule

// File: rtl/uv_shed_datapath.sv
module uv_shed_datapath
  import uv_shed_pkg::*;
#(
  parameter int SHED_TICKS = 100,
  parameter int HOLD_TICKS = 6000
) (
  input  logic       clk,
  input  logic       rst,
  input  uv_strobe_t strobe,
  output logic       shedBusy,
  output logic       holdDone
);

  localparam int SHED_W = cntWidth(SHED_TICKS);
  localparam int HOLD_W = cntWidth(HOLD_TICKS);
  localparam logic [SHED_W-1:0] SHED_LOAD = SHED_W'(SHED_TICKS);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

  logic [SHED_W-1:0] shedCnt;
  logic [HOLD_W-1:0] holdCnt;

  // Shed timer: loaded with the full width, counts down to zero.
  uv_tick_counter #(.WIDTH(SHED_W), .COUNTUP(1'b0)) u_shedCnt (
    .clk     (clk),
    .clr     (rst),
    .load    (strobe.shedLoad),
    .loadVal (SHED_LOAD),
    .step    (strobe.shedStep),
    .count   (shedCnt)
  );

  // Clear-window timer: counts consecutive clear ticks up from zero.
  uv_tick_counter #(.WIDTH(HOLD_W), .COUNTUP(1'b1)) u_holdCnt (
    .clk     (clk),
    .clr     (rst | strobe.holdClr),
    .load    (1'b0),
    .loadVal ('0),
    .step    (strobe.holdStep),
    .count   (holdCnt)
  );

  assign shedBusy = (shedCnt != '0);
  assign holdDone = (holdCnt == HOLD_LAST);

endmodule

// File: rtl/uv_shed_ctrl.sv
module uv_shed_ctrl
  import uv_shed_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       uvIn,
  input  logic       shedBusy,
  input  logic       holdDone,
  output uv_strobe_t strobe,
  output logic       lossOfPower
);

  logic uvPrev;
  logic onset;

  assign onset = tick & uvIn & ~uvPrev & ~lossOfPower & ~shedBusy;

  always_comb begin
    strobe          = '0;
    strobe.shedLoad = onset;
    strobe.shedStep = tick & shedBusy & ~onset;
    strobe.holdClr  = tick & (uvIn | (lossOfPower & holdDone));
    strobe.holdStep = tick & ~uvIn & lossOfPower & ~holdDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uvPrev      <= 1'b0;
      lossOfPower <= 1'b0;
    end else if (tick) begin
      uvPrev <= uvIn;
      if (uvIn) begin
        lossOfPower <= 1'b1;
      end else if (lossOfPower && holdDone) begin
        lossOfPower <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uv_shed_monitor.sv
module uv_shed_monitor
  import uv_shed_pkg::*;
#(
  parameter int SHED_TICKS = 100,
  parameter int HOLD_TICKS = 6000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic uvIn,
  output logic shedPulse,
  output logic lossOfPower
);

  uv_strobe_t strobe;
  logic       shedBusy;
  logic       holdDone;

  uv_shed_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .uvIn        (uvIn),
    .shedBusy    (shedBusy),
    .holdDone    (holdDone),
    .strobe      (strobe),
    .lossOfPower (lossOfPower)
  );

  uv_shed_datapath #(
    .SHED_TICKS (SHED_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .shedBusy (shedBusy),
    .holdDone (holdDone)
  );

  assign shedPulse = shedBusy;

endmodule

// File: rtl/uv_shed_monitor_chk.sv
module uv_shed_monitor_chk #(
  parameter int SHED_TICKS = 100,
  parameter int HOLD_TICKS = 6000
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic uvIn,
  input logic shedPulse,
  input logic lossOfPower
);

  localparam int SRUN_W = $clog2(SHED_TICKS + 2);
  localparam int CRUN_W = $clog2(HOLD_TICKS + 1);

  logic [SRUN_W-1:0] shedRun;   // ticks elapsed while the pulse is high
  logic [CRUN_W-1:0] clearRun;  // consecutive clear ticks, saturating

  always_ff @(posedge clk) begin
    if (rst || !shedPulse) begin
      shedRun <= '0;
    end else if (tick) begin
      shedRun <= shedRun + SRUN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (tick && uvIn)) begin
      clearRun <= '0;
    end else if (tick && !uvIn && clearRun != CRUN_W'(HOLD_TICKS)) begin
      clearRun <= clearRun + CRUN_W'(1);
    end
  end

  // R1: the pulse never outlives its window
  a_r1_shed_width: assert property (@(posedge clk) disable iff (rst)
    shedPulse |-> (shedRun < SRUN_W'(SHED_TICKS)));

  // R2: undervoltage on a tick sets the flag
  a_r2_lop_on_uv: assert property (@(posedge clk) disable iff (rst)
    (tick && uvIn) |=> lossOfPower);

  // R3: flag drops only after a full clear window
  a_r3_full_clear_window: assert property (@(posedge clk) disable iff (rst)
    $fell(lossOfPower) |-> (clearRun >= CRUN_W'(HOLD_TICKS)));

  // R3: the drop happens on a clear tick
  a_r3_fall_on_clear_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(lossOfPower) |-> $past(tick && !uvIn));

  // R5: a pulse only starts together with a fresh loss-of-power
  a_r5_shed_with_new_lop: assert property (@(posedge clk) disable iff (rst)
    $rose(shedPulse) |-> $rose(lossOfPower));

  // R6: nothing moves between ticks
  a_r6_idle_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(shedPulse) && $stable(lossOfPower)));

endmodule

bind uv_shed_monitor uv_shed_monitor_chk #(
  .SHED_TICKS (SHED_TICKS),
  .HOLD_TICKS (HOLD_TICKS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .uvIn        (uvIn),
  .shedPulse   (shedPulse),
  .lossOfPower (lossOfPower)
);

// File: tb/sim_uv_shed_monitor.sv
`timescale 1ns/1ps
module sim_uv_shed_monitor;

  localparam int SHED = 5;
  localparam int HOLD = 12;
  localparam int NVEC = 22;

  // Each entry: {uvIn on the tick, expected shedPulse, expected lossOfPower} after the tick
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, 3'b111, 3'b111, 3'b111, 3'b011, 3'b011, 3'b001, 3'b101,
    3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001,
    3'b001, 3'b001, 3'b001, 3'b000, 3'b000, 3'b111
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic uvIn = 1'b0;
  logic shedPulse;
  logic lossOfPower;
  int   nRun = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  uv_shed_monitor #(.SHED_TICKS(SHED), .HOLD_TICKS(HOLD)) u0 (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .uvIn        (uvIn),
    .shedPulse   (shedPulse),
    .lossOfPower (lossOfPower)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One tick cycle with the given input; outputs are sampled at the next falling edge.
  task automatic doTick(input logic uv);
    @(negedge clk);
    uvIn = uv;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "shed after reset", shedPulse, 1'b0);
    check("R7", "lop after reset", lossOfPower, 1'b0);
    rst = 1'b0;

    // Table walk: onset, pulse width, brief return inside the clear window, exact off-delay.
    for (int i = 0; i < NVEC; i++) begin
      doTick(VEC[i][2]);
      check("R1 R5", $sformatf("shed vec %0d", i), shedPulse, VEC[i][1]);
      check("R2 R3 R4", $sformatf("lop vec %0d", i), lossOfPower, VEC[i][0]);
    end

    // R6: input toggling without a tick has no effect
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      uvIn = k[0];
      check("R6", "shed between ticks", shedPulse, 1'b1);
      check("R6", "lop between ticks", lossOfPower, 1'b1);
    end

    // Partly count a clear window, letting the pulse run out on the way.
    for (int k = 1; k <= 6; k++) begin
      doTick(1'b0);
      if (k == 4) check("R1", "shed at tick 4", shedPulse, 1'b1);
      if (k == 5) check("R1", "shed at tick 5", shedPulse, 1'b0);
    end

    // R7: reset in the middle of the window, input held high through it
    @(negedge clk);
    rst = 1'b1;
    uvIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", "shed in reset", shedPulse, 1'b0);
    check("R7", "lop in reset", lossOfPower, 1'b0);
    rst = 1'b0;

    // R8: first tick after reset with input high is an onset
    doTick(1'b1);
    check("R8", "shed on first tick", shedPulse, 1'b1);
    check("R8", "lop on first tick", lossOfPower, 1'b1);

    // R7 and R3: the full window is needed again after reset
    for (int k = 1; k <= HOLD; k++) begin
      doTick(1'b0);
      if (k == SHED - 1) check("R1", "shed before end", shedPulse, 1'b1);
      if (k == SHED) check("R1", "shed at end", shedPulse, 1'b0);
      if (k == HOLD - 1) check("R7", "lop one tick early", lossOfPower, 1'b1);
      if (k == HOLD) check("R3", "lop at window end", lossOfPower, 1'b0);
    end

    // R5: toggling during a running pulse does not reload it
    doTick(1'b1);
    check("R5", "new onset shed", shedPulse, 1'b1);
    doTick(1'b0);
    doTick(1'b1);
    doTick(1'b0);
    doTick(1'b1);
    check("R5", "shed at 4th tick", shedPulse, 1'b1);
    doTick(1'b0);
    check("R5", "shed not reloaded", shedPulse, 1'b0);
    check("R2", "lop held", lossOfPower, 1'b1);

    finishRun();
  end

endmodule